// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block holds the exception bookkeeping for a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback. Each in-flight instruction travels with its own PC, a valid bit, a flagged bit and a three-bit cause. Faults can be reported by the fetch, decode, execute and memory stages, in any order in time. The controller only marks the instruction when a fault arrives. It does nothing else until that instruction reaches writeback. Older instructions always get to writeback first, so faults are handled in program order even when a younger instruction was flagged earlier in time.

When a flagged instruction sits in writeback, the controller does four things. It latches the instruction's PC and cause into the exception PC and cause registers. It sends fetch to a fixed vector address. It empties every younger stage. It switches the mode bits. A flagged instruction never writes the register file. A store is blocked if the store itself is flagged, or if the instruction in writeback is being taken in that cycle.

An external interrupt request enters the pipe as a flagged no-op, called a marker, that takes the place of the instruction being fetched. The surrounding datapath supplies the fault pulses, the store and write requests, and a return pulse that brings the processor back to user mode.

Top module: `excpipe_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the fetch PC equals RESET_PC (default 0). In that cycle supervisor is 0, interruptEnable is 1, and commitValid, excTaken and storeEnable are all 0.
- R2: With no exception and no injection, the fetch PC steps by INSTR_BYTES (4) every cycle. The instruction fetched in cycle n leaves writeback in cycle n+4, with commitValid=1 and commitPc equal to its fetch PC.
- R3: A fault report does not change fetch until the flagged instruction is in writeback. In that cycle excTaken is 1. In the next cycle fetchPc equals VECTOR (default 0x80) and epc holds the PC of the flagged instruction.
- R4: Faults are handled in program order. If an older instruction faults in a later stage after a younger one has already been flagged in an earlier stage, the older instruction's PC and cause are recorded.
- R5: Cause codes are 0 for an interrupt, 1 for a fetch translation fault, 2 for an illegal instruction, 3 for an overflow and 4 for a data translation fault. When one instruction is flagged in several stages, the earliest stage's code is kept.
- R6: Instructions in decode, execute and memory when an exception is taken never commit. The next commit is the vector instruction, four cycles after the vector fetch.
- R7: regWriteEnable is 1 only when the instruction in writeback is valid, unflagged and requests a write.
- R8: storeEnable is 0 when the store in memory is flagged, including by a data fault in that same cycle. It is also 0 while an exception is taken from writeback.
- R9: If irqReq is 1, interruptEnable is 1 and no marker is in flight, a marker with cause 0 is injected with the current fetch PC, and the fetch PC holds for that one cycle.
- R10: No second marker is injected while one is in flight, and no marker is injected while interruptEnable is 0.
- R11: Taking an exception sets supervisor and clears interruptEnable from the next cycle on. A retExc pulse clears supervisor and sets interruptEnable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Level interrupt request, held until serviced |
| retExc | input | 1 | Return pulse that restores user mode |
| ifFault | input | 1 | Fetch translation fault for the instruction being fetched |
| idFault | input | 1 | Illegal instruction in decode |
| exFault | input | 1 | Arithmetic overflow in execute |
| memFault | input | 1 | Data translation fault in memory |
| memIsStore | input | 1 | Instruction in memory is a store |
| wbWantsWrite | input | 1 | Instruction in writeback writes a register |
| fetchPc | output | PC_W | Address being fetched |
| excTaken | output | 1 | A flagged instruction is being taken from writeback |
| epc | output | PC_W | Latched exception PC |
| excCause | output | 3 | Latched exception cause |
| supervisor | output | 1 | Supervisor mode bit |
| interruptEnable | output | 1 | Interrupt enable bit |
| commitValid | output | 1 | An unflagged instruction retires this cycle |
| commitPc | output | PC_W | PC of the instruction in writeback |
| regWriteEnable | output | 1 | Register file write permitted |
| storeEnable | output | 1 | Store to memory permitted |

## Verification
The key case is a younger instruction that faults in fetch before an older one faults in memory. A design that acts on the first fault it sees would record the younger PC and cause 1 instead of cause 4. A second case flags one instruction in fetch, decode and execute. A design without earliest-stage priority would record the later overflow code. The interrupt scenario keeps the request high for many cycles. A design without the in-flight check would inject a stream of markers, one that forgets to hold the fetch PC would record the wrong return address, and one that ignores the enable bit would take a second exception inside the handler. The store cases show up as a store leaking out from under a flagged instruction or from behind an exception being taken.

// File: rtl/excpipe_pkg.sv
package excpipe_pkg;

  typedef enum logic [2:0] {
    CAUSE_IRQ  = 3'd0,
    CAUSE_ITLB = 3'd1,
    CAUSE_ILL  = 3'd2,
    CAUSE_OVF  = 3'd3,
    CAUSE_DTLB = 3'd4
  } cause_e;

  // strobes from control to the tracking datapath
  typedef struct packed {
    logic flush;   // take exception from writeback
    logic inject;  // put an interrupt marker in the fetch slot
  } ctl_strobe_t;

endpackage

// File: rtl/excpipe_track.sv
module excpipe_track
  import excpipe_pkg::*;
#(
  parameter int              PC_W        = 32,
  parameter int              INSTR_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC    = '0,
  parameter logic [PC_W-1:0] VECTOR      = PC_W'(128)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctl_strobe_t     ctl,
  input  logic [3:0]      stageFault,   // index 0 fetch .. 3 memory
  output logic [PC_W-1:0] fetchPc,
  output logic            memValid,
  output logic            memFlagNow,
  output logic            wbValid,
  output logic            wbFlag,
  output logic [PC_W-1:0] wbPc,
  output logic            markerInFlight,
  output logic [PC_W-1:0] epc,
  output cause_e          excCause
);

  localparam int              NST  = 4;          // decode, execute, memory, writeback
  localparam int              MEMI = NST - 1;
  localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

  logic [NST:1]    vQ, fQ, vN, fN, markerVec;
  logic [PC_W-1:0] pcQ [1:NST];
  logic [PC_W-1:0] pcN [1:NST];
  cause_e          cQ  [1:NST];
  cause_e          cN  [1:NST];
  logic [PC_W-1:0] fetchPcQ;

  // next-state of every slot; a fault only marks, earliest cause wins
  always_comb begin
    vN[1]  = 1'b1;
    pcN[1] = fetchPcQ;
    fN[1]  = ctl.inject | stageFault[0];
    cN[1]  = ctl.inject ? CAUSE_IRQ : CAUSE_ITLB;
    for (int k = 2; k <= NST; k++) begin
      vN[k]  = vQ[k-1];
      pcN[k] = pcQ[k-1];
      fN[k]  = fQ[k-1] | (vQ[k-1] & stageFault[k-1]);
      cN[k]  = fQ[k-1] ? cQ[k-1] : cause_e'(3'(k));
    end
  end

  always_comb begin
    for (int k = 1; k <= NST; k++)
      markerVec[k] = vQ[k] & fQ[k] & (cQ[k] == CAUSE_IRQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vQ       <= '0;
      fQ       <= '0;
      fetchPcQ <= RESET_PC;
      epc      <= '0;
      excCause <= CAUSE_IRQ;
      for (int k = 1; k <= NST; k++) begin
        pcQ[k] <= '0;
        cQ[k]  <= CAUSE_IRQ;
      end
    end else if (ctl.flush) begin
      vQ       <= '0;
      fQ       <= '0;
      fetchPcQ <= VECTOR;
      epc      <= pcQ[NST];
      excCause <= cQ[NST];
    end else begin
      vQ       <= vN;
      fQ       <= fN;
      fetchPcQ <= ctl.inject ? fetchPcQ : fetchPcQ + STEP;
      for (int k = 1; k <= NST; k++) begin
        pcQ[k] <= pcN[k];
        cQ[k]  <= cN[k];
      end
    end
  end

  assign fetchPc        = fetchPcQ;
  assign memValid       = vQ[MEMI];
  assign memFlagNow     = vQ[MEMI] & (fQ[MEMI] | stageFault[MEMI]);
  assign wbValid        = vQ[NST];
  assign wbFlag         = fQ[NST];
  assign wbPc           = pcQ[NST];
  assign markerInFlight = |markerVec;

  p_pc_advance_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(ctl.flush) && !$past(ctl.inject)) |-> fetchPc == $past(fetchPc) + STEP);

  p_vector_after_take_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> fetchPc == VECTOR);

  p_flush_younger_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> (!wbValid && !memValid && !markerInFlight));

  p_hold_on_inject_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.inject && !ctl.flush) |=> fetchPc == $past(fetchPc));

  p_single_marker_r10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(markerVec) <= 1);

endmodule

// File: rtl/excpipe_ctl.sv
module excpipe_ctl
  import excpipe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        irqReq,
  input  logic        retExc,
  input  logic        memIsStore,
  input  logic        wbWantsWrite,
  input  logic        memValid,
  input  logic        memFlagNow,
  input  logic        wbValid,
  input  logic        wbFlag,
  input  logic        markerInFlight,
  output ctl_strobe_t ctl,
  output logic        excTaken,
  output logic        commitValid,
  output logic        regWriteEnable,
  output logic        storeEnable,
  output logic        supervisor,
  output logic        interruptEnable
);

  logic supQ, ieQ;

  assign excTaken       = wbValid & wbFlag;
  assign ctl.flush      = excTaken;
  assign ctl.inject     = irqReq & ieQ & ~markerInFlight & ~excTaken;
  assign commitValid    = wbValid & ~wbFlag;
  assign regWriteEnable = commitValid & wbWantsWrite;
  assign storeEnable    = memIsStore & memValid & ~memFlagNow & ~excTaken;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      supQ <= 1'b0;
      ieQ  <= 1'b1;
    end else if (excTaken) begin
      supQ <= 1'b1;
      ieQ  <= 1'b0;
    end else if (retExc) begin
      supQ <= 1'b0;
      ieQ  <= 1'b1;
    end
  end

  assign supervisor      = supQ;
  assign interruptEnable = ieQ;

  p_mode_on_take_r11: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |=> (supervisor && !interruptEnable));

endmodule

// File: rtl/excpipe_ctrl.sv
module excpipe_ctrl
  import excpipe_pkg::*;
#(
  parameter int              PC_W        = 32,
  parameter int              INSTR_BYTES = 4,
  parameter logic [PC_W-1:0] RESET_PC    = '0,
  parameter logic [PC_W-1:0] VECTOR      = PC_W'(128)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            irqReq,
  input  logic            retExc,
  input  logic            ifFault,
  input  logic            idFault,
  input  logic            exFault,
  input  logic            memFault,
  input  logic            memIsStore,
  input  logic            wbWantsWrite,
  output logic [PC_W-1:0] fetchPc,
  output logic            excTaken,
  output logic [PC_W-1:0] epc,
  output logic [2:0]      excCause,
  output logic            supervisor,
  output logic            interruptEnable,
  output logic            commitValid,
  output logic [PC_W-1:0] commitPc,
  output logic            regWriteEnable,
  output logic            storeEnable
);

  ctl_strobe_t ctl;
  cause_e      causeQ;
  logic        memValid, memFlagNow, wbValid, wbFlag, markerInFlight;

  excpipe_track #(
    .PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES), .RESET_PC(RESET_PC), .VECTOR(VECTOR)
  ) u_track (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .stageFault({memFault, exFault, idFault, ifFault}),
    .fetchPc(fetchPc), .memValid(memValid), .memFlagNow(memFlagNow),
    .wbValid(wbValid), .wbFlag(wbFlag), .wbPc(commitPc),
    .markerInFlight(markerInFlight), .epc(epc), .excCause(causeQ)
  );

  excpipe_ctl u_ctl (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .retExc(retExc),
    .memIsStore(memIsStore), .wbWantsWrite(wbWantsWrite),
    .memValid(memValid), .memFlagNow(memFlagNow),
    .wbValid(wbValid), .wbFlag(wbFlag), .markerInFlight(markerInFlight),
    .ctl(ctl), .excTaken(excTaken), .commitValid(commitValid),
    .regWriteEnable(regWriteEnable), .storeEnable(storeEnable),
    .supervisor(supervisor), .interruptEnable(interruptEnable)
  );

  assign excCause = causeQ;

endmodule

// File: tb/sim_excpipe_ctrl.sv
`timescale 1ns/1ps
module sim_excpipe_ctrl;

  localparam logic [31:0] VEC = 32'h80;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqReq = 0, retExc = 0, ifFault = 0, idFault = 0, exFault = 0, memFault = 0;
  logic memIsStore = 0, wbWantsWrite = 0;
  logic [31:0] fetchPc, epc, commitPc;
  logic [2:0]  excCause;
  logic excTaken, supervisor, interruptEnable, commitValid, regWriteEnable, storeEnable;

  int nChecks = 0;
  int nFail = 0;

  always #4 clk = ~clk;  // 125 MHz

  excpipe_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .retExc(retExc),
    .ifFault(ifFault), .idFault(idFault), .exFault(exFault), .memFault(memFault),
    .memIsStore(memIsStore), .wbWantsWrite(wbWantsWrite),
    .fetchPc(fetchPc), .excTaken(excTaken), .epc(epc), .excCause(excCause),
    .supervisor(supervisor), .interruptEnable(interruptEnable),
    .commitValid(commitValid), .commitPc(commitPc),
    .regWriteEnable(regWriteEnable), .storeEnable(storeEnable)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // faults packed {mem, ex, id, if}
  task automatic setIn(input logic [3:0] f, input logic irq, input logic ret, input logic st, input logic wr);
    {memFault, exFault, idFault, ifFault} = f;
    irqReq = irq; retExc = ret; memIsStore = st; wbWantsWrite = wr;
  endtask

  // leaves the bench in cycle 0: just after a negedge, reset released
  task automatic doReset();
    setIn(4'b0, 0, 0, 0, 0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    #1;
    chk("R1", "fetchPc", fetchPc, 32'h0);
    chk("R1", "supervisor", 32'(supervisor), 32'd0);
    chk("R1", "interruptEnable", 32'(interruptEnable), 32'd1);
    chk("R1", "commitValid", 32'(commitValid), 32'd0);
    chk("R1", "excTaken", 32'(excTaken), 32'd0);
    chk("R1", "storeEnable", 32'(storeEnable), 32'd0);
  endtask

  task automatic testFlow();
    doReset();
    for (int n = 0; n < 9; n++) begin
      setIn(4'b0, 0, 0, 0, 1);
      #1;
      if (n == 3) chk("R2", "no commit before pipe fills", 32'(commitValid), 32'd0);
      if (n == 4) chk("R2", "first commit pc", commitPc, 32'h0);
      if (n == 4) chk("R2", "first commitValid", 32'(commitValid), 32'd1);
      if (n == 7) chk("R2", "commit pc n=7", commitPc, 32'd12);
      if (n == 7) chk("R7", "regWrite unflagged", 32'(regWriteEnable), 32'd1);
      if (n == 8) chk("R2", "fetchPc n=8", fetchPc, 32'd32);
      @(negedge clk);
    end
  endtask

  // overflow on PC 8 (in execute in cycle 4), with stores around it
  task automatic testOverflow();
    doReset();
    for (int n = 0; n < 12; n++) begin
      setIn((n == 4) ? 4'b0100 : 4'b0, 0, 0, (n >= 3 && n <= 6), 1);
      #1;
      if (n == 4) chk("R8", "unflagged store allowed", 32'(storeEnable), 32'd1);
      if (n == 5) chk("R3", "no action before writeback", 32'(excTaken), 32'd0);
      if (n == 5) chk("R8", "flagged store blocked", 32'(storeEnable), 32'd0);
      if (n == 6) chk("R3", "taken at writeback", 32'(excTaken), 32'd1);
      if (n == 6) chk("R7", "flagged no regWrite", 32'(regWriteEnable), 32'd0);
      if (n == 6) chk("R8", "store behind taken exc blocked", 32'(storeEnable), 32'd0);
      if (n == 7) chk("R3", "fetch at vector", fetchPc, VEC);
      if (n == 7) chk("R3", "epc", epc, 32'd8);
      if (n == 7) chk("R5", "cause overflow=3", 32'(excCause), 32'd3);
      if (n == 7) chk("R11", "supervisor set", 32'(supervisor), 32'd1);
      if (n == 7) chk("R11", "interruptEnable cleared", 32'(interruptEnable), 32'd0);
      if (n == 7 || n == 10) chk("R6", "younger squashed", 32'(commitValid), 32'd0);
      if (n == 11) chk("R6", "vector instr commits", commitPc, VEC);
      @(negedge clk);
    end
  endtask

  // younger PC 8 faults in fetch (cycle 2) before older PC 4 faults in memory (cycle 4)
  task automatic testOrder();
    doReset();
    for (int n = 0; n < 7; n++) begin
      logic [3:0] f;
      f = 4'b0;
      if (n == 2) f = 4'b0001;
      if (n == 4) f = 4'b1000;
      setIn(f, 0, 0, (n == 4), 0);
      #1;
      if (n == 4) chk("R8", "store with data fault blocked", 32'(storeEnable), 32'd0);
      if (n == 4) chk("R3", "younger flag not acted on", 32'(excTaken), 32'd0);
      if (n == 5) chk("R4", "older taken first", 32'(excTaken), 32'd1);
      if (n == 6) chk("R4", "epc of older", epc, 32'd4);
      if (n == 6) chk("R5", "cause data fault=4", 32'(excCause), 32'd4);
      @(negedge clk);
    end
  endtask

  // PC 0 flagged in fetch, decode and execute
  task automatic testPriority();
    doReset();
    for (int n = 0; n < 6; n++) begin
      logic [3:0] f;
      f = 4'b0;
      if (n == 0) f = 4'b0001;
      if (n == 1) f = 4'b0010;
      if (n == 2) f = 4'b0100;
      setIn(f, 0, 0, 0, 0);
      #1;
      if (n == 3) chk("R3", "fetch not redirected early", fetchPc, 32'd12);
      if (n == 5) chk("R5", "earliest cause=1", 32'(excCause), 32'd1);
      if (n == 5) chk("R5", "epc", epc, 32'd0);
      @(negedge clk);
    end
  endtask

  task automatic testInterrupt();
    doReset();
    for (int n = 0; n < 19; n++) begin
      setIn(4'b0, (n >= 2 && n <= 17), (n == 12), 0, 0);
      #1;
      if (n == 3) chk("R9", "fetch held on inject", fetchPc, 32'd8);
      if (n == 4) chk("R10", "no reinjection in flight", fetchPc, 32'd12);
      if (n == 6) chk("R9", "marker taken", 32'(excTaken), 32'd1);
      if (n == 6) chk("R9", "marker no commit", 32'(commitValid), 32'd0);
      if (n == 7) chk("R9", "marker epc", epc, 32'd8);
      if (n == 7) chk("R5", "cause irq=0", 32'(excCause), 32'd0);
      if (n == 8) chk("R10", "no inject when disabled", fetchPc, VEC + 32'd4);
      if (n == 11) chk("R10", "no exception when disabled", 32'(excTaken), 32'd0);
      if (n == 13) chk("R11", "ret clears supervisor", 32'(supervisor), 32'd0);
      if (n == 13) chk("R11", "ret sets interruptEnable", 32'(interruptEnable), 32'd1);
      if (n == 14) chk("R9", "reinject hold", fetchPc, VEC + 32'd24);
      if (n == 17) chk("R9", "second marker taken", 32'(excTaken), 32'd1);
      if (n == 18) chk("R9", "second epc", epc, VEC + 32'd24);
      @(negedge clk);
    end
  endtask

  task automatic report();
    $display("  TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testFlow();
    testOverflow();
    testOrder();
    testPriority();
    testInterrupt();
    report();
    $finish;
  end

endmodule